// File: doc/BRIEF.md
# Write-Select Clear Status Registers

This block keeps the latched alarm and event flags of a line transceiver and drives its active-low interrupt line. Each flag has one source input. A flag is either level-set, which sets it in any cycle where its source is high, or change-set, which sets it whenever its source differs from the value sampled one cycle earlier. A change-set flag therefore reports both the start and the end of an alarm. Once set, a flag stays set until software clears it.

Software reads and clears flags in two steps over a small synchronous register port. First it writes a select byte to the status address. Each 1 in that byte names a flag to collect. The next read of that address returns exactly those flags and clears them. It also uses up the select byte, so flags that were not named survive the read and read back as 0. A per-flag mask register decides which set flags pull the interrupt line low.

Top module: `wsc_status_regs`

## Requirements
- R1: Reset clears every status flag, every select byte, every mask byte and the read data, and drives `irq_no` high.
- R2: A flag whose bit in `EDGE_MASK` is 0 sets on the clock edge that samples its `src_i` bit high. It then stays set until it is cleared, even after the source drops.
- R3: A flag whose bit in `EDGE_MASK` is 1 sets on the clock edge where its `src_i` bit differs from the value sampled at the previous edge. This covers both a rise and a fall. The sampled history resets to 0.
- R4: A write to address r (0 to NUM_REGS-1) stores `bus_wdata_i` as the select byte of status register r. It changes no status flag.
- R5: A read of address r (0 to NUM_REGS-1) loads `bus_rdata_o` on that edge with status r ANDed with its select byte. It clears those selected flags and resets the select byte to 0. `bus_rdata_o` keeps its value until the next read.
- R6: Flags not selected by the preceding write keep their value through the read and appear as 0 in the read data.
- R7: A flag whose set condition is true on the same edge as the read that clears it stays set.
- R8: Address NUM_REGS+r holds mask byte r, which can be written and read back. Mask bit 1 lets the flag assert the interrupt; mask bit 0 blocks it.
- R9: `irq_no` is low exactly while some flag is set with its mask bit at 1.
- R10: A read that follows no select write, or a second read after a clearing read, returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_REGS*DATA_W | Alarm and event sources. Flag b of register r is bit r*DATA_W+b |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_addr_i | input | ADDR_W | Register address: status 0..NUM_REGS-1, masks NUM_REGS..2*NUM_REGS-1 |
| bus_wdata_i | input | DATA_W | Write data (select byte or mask byte) |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions assume that the write and read strobes are never high together. They also assume that `src_i` is steady around each rising edge. The bench keeps to both: it changes every input only on falling edges, and it issues at most one bus operation per cycle. It holds the sources at 0 during reset, so change-set flags see no spurious edge on release. The checker also waits one cycle after reset before it compares anything against earlier cycles.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } bus_op_e;

    function automatic bus_op_e decode_op(input logic wr, input logic rd);
        if (rd)      return OP_READ;
        else if (wr) return OP_WRITE;
        else         return OP_IDLE;
    endfunction

endpackage

// File: rtl/wsc_set_gen.sv
module wsc_set_gen #(
    parameter int          NBITS     = 16,
    parameter logic [NBITS-1:0] EDGE_MASK = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NBITS-1:0] src_i,
    output logic [NBITS-1:0] set_o
);

    logic [NBITS-1:0] hist_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= src_i;
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_change
            assign set_o[i] = src_i[i] ^ hist_q[i];
        end else begin : g_level
            assign set_o[i] = src_i[i];
        end
    end

endmodule

// File: rtl/wsc_irq.sv
module wsc_irq #(
    parameter int NBITS = 16
) (
    input  logic [NBITS-1:0] flags_i,
    input  logic [NBITS-1:0] enable_i,
    output logic             irq_no
);

    assign irq_no = ~|(flags_i & enable_i);

endmodule

// File: rtl/wsc_status_regs.sv
module wsc_status_regs #(
    parameter int NUM_REGS = 2,
    parameter int DATA_W   = 8,
    parameter logic [NUM_REGS*DATA_W-1:0] EDGE_MASK = 16'h000F,
    localparam int NBITS   = NUM_REGS * DATA_W,
    localparam int ADDR_W  = $clog2(2 * NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NBITS-1:0]  src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_no
);

    import wsc_pkg::*;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] stat;
        logic [NUM_REGS-1:0][DATA_W-1:0] sel;
        logic [NUM_REGS-1:0][DATA_W-1:0] mask;
        logic [DATA_W-1:0]               rdata;
    } state_t;

    state_t     st_d, st_q;
    bus_op_e    op;
    logic [NBITS-1:0] set_vec;
    logic [NBITS-1:0] stat_vec;
    logic [NBITS-1:0] sel_vec;
    logic [NBITS-1:0] mask_vec;

    wsc_set_gen #(
        .NBITS     (NBITS),
        .EDGE_MASK (EDGE_MASK)
    ) u_set (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .set_o  (set_vec)
    );

    assign op = decode_op(bus_wr_i, bus_rd_i);

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            st_d.stat[r] = st_q.stat[r] | set_vec[r*DATA_W +: DATA_W];
            if (op == OP_WRITE) begin
                if (int'(bus_addr_i) == r)            st_d.sel[r]  = bus_wdata_i;
                if (int'(bus_addr_i) == NUM_REGS + r) st_d.mask[r] = bus_wdata_i;
            end
            if (op == OP_READ) begin
                if (int'(bus_addr_i) == r) begin
                    st_d.rdata   = st_q.stat[r] & st_q.sel[r];
                    st_d.stat[r] = (st_q.stat[r] & ~st_q.sel[r])
                                 | set_vec[r*DATA_W +: DATA_W];
                    st_d.sel[r]  = '0;
                end
                if (int'(bus_addr_i) == NUM_REGS + r) st_d.rdata = st_q.mask[r];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_vec    = st_q.stat;
    assign sel_vec     = st_q.sel;
    assign mask_vec    = st_q.mask;
    assign bus_rdata_o = st_q.rdata;

    wsc_irq #(
        .NBITS (NBITS)
    ) u_irq (
        .flags_i  (stat_vec),
        .enable_i (mask_vec),
        .irq_no   (irq_no)
    );

endmodule

// File: rtl/wsc_status_chk.sv
module wsc_status_chk #(
    parameter int NUM_REGS = 2,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       bus_wr_i,
    input logic                       bus_rd_i,
    input logic [ADDR_W-1:0]          bus_addr_i,
    input logic [DATA_W-1:0]          bus_wdata_i,
    input logic [DATA_W-1:0]          bus_rdata_o,
    input logic [NUM_REGS*DATA_W-1:0] stat_vec,
    input logic [NUM_REGS*DATA_W-1:0] sel_vec,
    input logic [NUM_REGS*DATA_W-1:0] mask_vec,
    input logic [NUM_REGS*DATA_W-1:0] set_vec
);

    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    p_one_op_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_wr_i && bus_rd_i));

    // R2 R3 R7: a set condition always leaves the flag set on the next cycle
    p_set_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> (($past(set_vec) & ~stat_vec) == '0));

    // R2 R3: no flag rises without a set condition
    p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> ((stat_vec & ~$past(stat_vec) & ~$past(set_vec)) == '0));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        p_sel_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_wr_i && int'(bus_addr_i) == r)
            |=> (sel_vec[r*DATA_W +: DATA_W] == $past(bus_wdata_i)));

        p_rd_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_rd_i && int'(bus_addr_i) == r)
            |=> (bus_rdata_o == $past(stat_vec[r*DATA_W +: DATA_W]
                                    & sel_vec[r*DATA_W +: DATA_W])));

        p_keep_unsel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_rd_i && int'(bus_addr_i) == r)
            |=> (($past(stat_vec[r*DATA_W +: DATA_W] & ~sel_vec[r*DATA_W +: DATA_W])
                  & ~stat_vec[r*DATA_W +: DATA_W]) == '0));

        p_mask_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_wr_i && int'(bus_addr_i) == NUM_REGS + r)
            |=> (mask_vec[r*DATA_W +: DATA_W] == $past(bus_wdata_i)));
    end

endmodule

bind wsc_status_regs wsc_status_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .stat_vec    (stat_vec),
    .sel_vec     (sel_vec),
    .mask_vec    (mask_vec),
    .set_vec     (set_vec)
);

// File: tb/tb_wsc_status_regs.sv
module tb_wsc_status_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 2;
    localparam int DW   = 8;
    localparam int NB   = NREG * DW;
    localparam int AW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] src = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsc_status_regs #(
        .NUM_REGS  (NREG),
        .DATA_W    (DW),
        .EDGE_MASK (16'h000F)
    ) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_no      (irq_n)
    );

    // op: 0 idle, 1 write, 2 read
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [7:0]  wdata;
        logic [15:0] src;
        logic [7:0]  exp_rd;
        logic        exp_irq_n;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 2'd2, 8'hFF, 16'h0000, 8'h00, 1'b1, 4'd8},  // R8 mask0 all on
        '{2'd0, 2'd0, 8'h00, 16'h0030, 8'h00, 1'b0, 4'd2},  // R2 level set
        '{2'd0, 2'd0, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd2},  // R2 stays set
        '{2'd1, 2'd0, 8'h10, 16'h0000, 8'h00, 1'b0, 4'd4},  // R4 select
        '{2'd2, 2'd0, 8'h00, 16'h0000, 8'h10, 1'b0, 4'd5},  // R5 R6 read
        '{2'd2, 2'd0, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd10}, // R10 second read
        '{2'd1, 2'd0, 8'h20, 16'h0000, 8'h00, 1'b0, 4'd5},  // R5 rdata holds
        '{2'd2, 2'd0, 8'h00, 16'h0020, 8'h20, 1'b0, 4'd7},  // R7 collision
        '{2'd1, 2'd0, 8'h20, 16'h0000, 8'h20, 1'b0, 4'd7},  // R7 flag kept
        '{2'd2, 2'd0, 8'h00, 16'h0000, 8'h20, 1'b1, 4'd9},  // R9 released
        '{2'd0, 2'd0, 8'h00, 16'h0001, 8'h20, 1'b0, 4'd3},  // R3 rise
        '{2'd1, 2'd0, 8'h01, 16'h0001, 8'h20, 1'b0, 4'd3},  // R3 steady
        '{2'd2, 2'd0, 8'h00, 16'h0001, 8'h01, 1'b1, 4'd3},  // R3 no reset
        '{2'd0, 2'd0, 8'h00, 16'h0000, 8'h01, 1'b0, 4'd3},  // R3 fall
        '{2'd1, 2'd0, 8'h01, 16'h0000, 8'h01, 1'b0, 4'd3},
        '{2'd2, 2'd0, 8'h00, 16'h0000, 8'h01, 1'b1, 4'd3},
        '{2'd0, 2'd0, 8'h00, 16'h0100, 8'h01, 1'b1, 4'd8},  // R8 masked
        '{2'd1, 2'd3, 8'h01, 16'h0000, 8'h01, 1'b0, 4'd8},  // R8 enable
        '{2'd2, 2'd3, 8'h00, 16'h0000, 8'h01, 1'b0, 4'd8},  // R8 readback
        '{2'd1, 2'd1, 8'hFF, 16'h0000, 8'h01, 1'b0, 4'd4},  // R4 no clear
        '{2'd2, 2'd1, 8'h00, 16'h0000, 8'h01, 1'b1, 4'd5}   // R5 reg1
    };

    task automatic check(input string tag, input logic [DW-1:0] exp_rd,
                         input logic exp_irq);
        checks++;
        if (rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata actual %02h expected %02h", tag, rdata, exp_rd);
        end
        checks++;
        if (irq_n !== exp_irq) begin
            errors++;
            $display("FAIL %s irq_n actual %0b expected %0b", tag, irq_n, exp_irq);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [NB-1:0] s);
        wr    = (op == 2'd1);
        rd    = (op == 2'd2);
        addr  = a;
        wdata = d;
        src   = s;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 8'h00, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].src);
            check($sformatf("R%0d vec %0d", VECS[i].req, i),
                  VECS[i].exp_rd, VECS[i].exp_irq_n);
        end

        // R6: two flags set, only one selected
        step(2'd0, 2'd0, 8'h00, 16'h0050);
        step(2'd0, 2'd0, 8'h00, 16'h0000);
        step(2'd1, 2'd0, 8'h40, 16'h0000);
        step(2'd2, 2'd0, 8'h00, 16'h0000);
        check("R6 partial", 8'h40, 1'b0);
        step(2'd1, 2'd0, 8'hFF, 16'h0000);
        step(2'd2, 2'd0, 8'h00, 16'h0000);
        check("R6 survivor", 8'h10, 1'b1);

        // R1: reset in mid run clears flags and masks
        step(2'd0, 2'd0, 8'h00, 16'h0020);
        step(2'd0, 2'd0, 8'h00, 16'h0000);
        check("R1 pre", 8'h10, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid reset", 8'h00, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        step(2'd1, 2'd0, 8'hFF, 16'h0000);
        step(2'd2, 2'd0, 8'h00, 16'h0000);
        check("R1 flags cleared", 8'h00, 1'b1);
        step(2'd1, 2'd0, 8'hFF, 16'h0000);
        step(2'd2, 2'd2, 8'h00, 16'h0000);
        check("R1 mask cleared", 8'h00, 1'b1);

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule